// File: doc/BRIEF.md
# Dual-Port Synchronous RAM Core

This block is a true two-port synchronous memory. A left port and a right port each run from their own clock and may read or write any word at any time, the same word included. On each port the request is captured at a rising clock edge: address, write data, a write select, an active-low output enable and a pair of chip enables, one active-low and one active-high. A write completes within the cycle that follows its capture edge. The address for each port comes from an external burst counter, which is not part of this block.

Each port has a mode input that sets its read latency. In flow-through mode, read data appears in the cycle after the capture edge, decoded straight from the registered address. In pipelined mode, an output register adds one more clock. Each port reports read data together with a valid flag. The flag stands in for a driven data bus: it is low when the port is deselected, when it is writing, or when its output enable is inactive. When both ports write one word on the same edge, the left port wins and both ports raise a collision flag for one cycle. The default depth is kept small so the project elaborates quickly. The address width is a parameter, and 17 bits gives the full 128K-word array.

Top module: `dpr_core`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `dvalid_*` and `collide_*` are low on both ports.
- R2: In flow-through mode (`pipe_*`=0), a read captured at an edge drives `dout_*` with the stored word and raises `dvalid_*` in the following cycle. A write captured at an edge is stored by the next edge and is visible to a read captured at that next edge. A write never raises `dvalid_*`.
- R3: In pipelined mode (`pipe_*`=1), `dvalid_*` stays low in the cycle after the capture edge. Read data and `dvalid_*` appear one cycle later.
- R4: A port is selected only when `ce0_n_*`=0 and `ce1_*`=1. With any other combination a write stores nothing, and a read leaves `dvalid_*` low with flow-through `dout_*` at zero.
- R5: With `oe_n_*`=1 at the capture edge, a read leaves `dvalid_*` low, and flow-through `dout_*` is zero.
- R6: Both ports share one array. A word written by either port can be read by the other. Writes on the same edge to different addresses both land and raise no collision flag.
- R7: When both ports write the same address on the same edge, the left port's data is kept. `collide_l` and `collide_r` are high for exactly the cycle after the commit edge.
- R8: A read captured on the same edge as a write by the other port to the same address returns the word held before that write.
- R9: In pipelined mode, while the port is deselected, `dout_*` keeps the last read word and `dvalid_*` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_l | input | 1 | Left port clock |
| rst_l | input | 1 | Left synchronous reset, active high |
| ce0_n_l | input | 1 | Left chip enable, active low |
| ce1_l | input | 1 | Left chip enable, active high |
| wr_l | input | 1 | Left write select, 1 = write, 0 = read |
| oe_n_l | input | 1 | Left output enable, active low |
| pipe_l | input | 1 | Left read mode, 1 = pipelined, 0 = flow-through |
| addr_l | input | ADDR_W | Left word address |
| din_l | input | DATA_W | Left write data |
| dout_l | output | DATA_W | Left read data |
| dvalid_l | output | 1 | Left read data valid (bus driven) |
| collide_l | output | 1 | Same-address write collision, left clock domain |
| clk_r | input | 1 | Right port clock |
| rst_r | input | 1 | Right synchronous reset, active high |
| ce0_n_r | input | 1 | Right chip enable, active low |
| ce1_r | input | 1 | Right chip enable, active high |
| wr_r | input | 1 | Right write select, 1 = write, 0 = read |
| oe_n_r | input | 1 | Right output enable, active low |
| pipe_r | input | 1 | Right read mode, 1 = pipelined, 0 = flow-through |
| addr_r | input | ADDR_W | Right word address |
| din_r | input | DATA_W | Right write data |
| dout_r | output | DATA_W | Right read data |
| dvalid_r | output | 1 | Right read data valid (bus driven) |
| collide_r | output | 1 | Same-address write collision, right clock domain |

## Verification
A corrupted word-ownership bit selects the wrong storage bank. The next read of that word on either port returns stale data: one cycle after capture in flow-through mode, or two cycles after in pipelined mode. A wrong select or output-enable register shows at once as a valid flag that disagrees with the inputs sampled one edge earlier, or two edges earlier in pipelined mode. A broken collision path shows in the cycle after the commit edge, either as a missing flag or as the right port's data winning the word.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  typedef enum logic {
    RD_FLOW = 1'b0,
    RD_PIPE = 1'b1
  } rd_mode_e;

  // Port is active only for the one enable combination
  function automatic logic port_enabled(input logic ce0_n, input logic ce1);
    return !ce0_n && ce1;
  endfunction

endpackage

// File: rtl/dpr_port.sv
module dpr_port
  import dpr_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce0_n,
  input  logic          ce1,
  input  logic          wr,
  input  logic          oe_n,
  input  logic          pipe,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] acc_addr,
  output logic          acc_wr,
  output logic [DW-1:0] acc_din,
  output logic [DW-1:0] dout,
  output logic          dvalid
);

  logic          sel_q, wr_q, oe_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] din_q;
  logic          rd_act;
  logic [DW-1:0] pipe_data;
  logic          pipe_vld;
  rd_mode_e      mode;

  assign mode = rd_mode_e'(pipe);

  // Input register stage: control is reset, data path is not
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= 1'b0;
      wr_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sel_q <= port_enabled(ce0_n, ce1);
      wr_q  <= wr;
      oe_q  <= !oe_n;
    end
    addr_q <= addr;
    din_q  <= din;
  end

  assign rd_act   = sel_q & ~wr_q;
  assign acc_wr   = sel_q & wr_q;
  assign acc_addr = addr_q;
  assign acc_din  = din_q;

  // Output register for pipelined mode; holds while no read is active
  always_ff @(posedge clk) begin
    if (rst) begin
      pipe_data <= '0;
      pipe_vld  <= 1'b0;
    end else begin
      pipe_vld <= rd_act & oe_q;
      if (rd_act) pipe_data <= rd_data;
    end
  end

  always_comb begin
    if (mode == RD_PIPE) begin
      dout   = pipe_data;
      dvalid = pipe_vld;
    end else begin
      dvalid = rd_act & oe_q;
      dout   = dvalid ? rd_data : '0;
    end
  end

endmodule

// File: rtl/dpr_lvt_ram.sv
module dpr_lvt_ram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk_a,
  input  logic          rst_a,
  input  logic          we_a,
  input  logic [AW-1:0] addr_a,
  input  logic [DW-1:0] din_a,
  output logic [DW-1:0] rdata_a,
  output logic          col_a,
  input  logic          clk_b,
  input  logic          rst_b,
  input  logic          we_b,
  input  logic [AW-1:0] addr_b,
  input  logic [DW-1:0] din_b,
  output logic [DW-1:0] rdata_b,
  output logic          col_b
);

  localparam int DEPTH = 1 << AW;

  // One bank per writing port; a tag pair per word records the last writer
  logic [DW-1:0] bank_a [DEPTH];
  logic [DW-1:0] bank_b [DEPTH];
  logic          tag_a  [DEPTH];
  logic          tag_b  [DEPTH];

  logic clash, we_b_eff;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      tag_a[i] = 1'b0;
      tag_b[i] = 1'b0;
    end
  end

  assign clash    = we_a & we_b & (addr_a == addr_b);
  assign we_b_eff = we_b & ~clash;

  // Port A write: equal tags mark bank A as the live copy
  always_ff @(posedge clk_a) begin
    if (we_a) begin
      bank_a[addr_a] <= din_a;
      tag_a[addr_a]  <= tag_b[addr_a];
    end
  end

  // Port B write: unequal tags mark bank B as the live copy
  always_ff @(posedge clk_b) begin
    if (we_b_eff) begin
      bank_b[addr_b] <= din_b;
      tag_b[addr_b]  <= ~tag_a[addr_b];
    end
  end

  always_ff @(posedge clk_a) begin
    if (rst_a) col_a <= 1'b0;
    else       col_a <= clash;
  end

  always_ff @(posedge clk_b) begin
    if (rst_b) col_b <= 1'b0;
    else       col_b <= clash;
  end

  assign rdata_a = (tag_a[addr_a] == tag_b[addr_a]) ? bank_a[addr_a] : bank_b[addr_a];
  assign rdata_b = (tag_a[addr_b] == tag_b[addr_b]) ? bank_a[addr_b] : bank_b[addr_b];

endmodule

// File: rtl/dpr_core.sv
module dpr_core #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk_l,
  input  logic              rst_l,
  input  logic              ce0_n_l,
  input  logic              ce1_l,
  input  logic              wr_l,
  input  logic              oe_n_l,
  input  logic              pipe_l,
  input  logic [ADDR_W-1:0] addr_l,
  input  logic [DATA_W-1:0] din_l,
  output logic [DATA_W-1:0] dout_l,
  output logic              dvalid_l,
  output logic              collide_l,
  input  logic              clk_r,
  input  logic              rst_r,
  input  logic              ce0_n_r,
  input  logic              ce1_r,
  input  logic              wr_r,
  input  logic              oe_n_r,
  input  logic              pipe_r,
  input  logic [ADDR_W-1:0] addr_r,
  input  logic [DATA_W-1:0] din_r,
  output logic [DATA_W-1:0] dout_r,
  output logic              dvalid_r,
  output logic              collide_r
);

  logic [ADDR_W-1:0] acc_addr_l, acc_addr_r;
  logic [DATA_W-1:0] acc_din_l, acc_din_r;
  logic [DATA_W-1:0] rdata_l, rdata_r;
  logic              acc_wr_l, acc_wr_r;

  dpr_port #(.AW(ADDR_W), .DW(DATA_W)) port_l_i (
    .clk(clk_l), .rst(rst_l), .ce0_n(ce0_n_l), .ce1(ce1_l), .wr(wr_l),
    .oe_n(oe_n_l), .pipe(pipe_l), .addr(addr_l), .din(din_l),
    .rd_data(rdata_l), .acc_addr(acc_addr_l), .acc_wr(acc_wr_l),
    .acc_din(acc_din_l), .dout(dout_l), .dvalid(dvalid_l)
  );

  dpr_port #(.AW(ADDR_W), .DW(DATA_W)) port_r_i (
    .clk(clk_r), .rst(rst_r), .ce0_n(ce0_n_r), .ce1(ce1_r), .wr(wr_r),
    .oe_n(oe_n_r), .pipe(pipe_r), .addr(addr_r), .din(din_r),
    .rd_data(rdata_r), .acc_addr(acc_addr_r), .acc_wr(acc_wr_r),
    .acc_din(acc_din_r), .dout(dout_r), .dvalid(dvalid_r)
  );

  // Left port is side A, which wins a same-address write clash
  dpr_lvt_ram #(.AW(ADDR_W), .DW(DATA_W)) ram_i (
    .clk_a(clk_l), .rst_a(rst_l), .we_a(acc_wr_l), .addr_a(acc_addr_l),
    .din_a(acc_din_l), .rdata_a(rdata_l), .col_a(collide_l),
    .clk_b(clk_r), .rst_b(rst_r), .we_b(acc_wr_r), .addr_b(acc_addr_r),
    .din_b(acc_din_r), .rdata_b(rdata_r), .col_b(collide_r)
  );

endmodule

// File: rtl/dpr_core_chk.sv
module dpr_core_chk #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input logic              clk_l,
  input logic              rst_l,
  input logic              ce0_n_l,
  input logic              ce1_l,
  input logic              wr_l,
  input logic              oe_n_l,
  input logic              pipe_l,
  input logic [ADDR_W-1:0] addr_l,
  input logic [DATA_W-1:0] din_l,
  input logic [DATA_W-1:0] dout_l,
  input logic              dvalid_l,
  input logic              collide_l,
  input logic              clk_r,
  input logic              rst_r,
  input logic              ce0_n_r,
  input logic              ce1_r,
  input logic              wr_r,
  input logic              oe_n_r,
  input logic              pipe_r,
  input logic [ADDR_W-1:0] addr_r,
  input logic [DATA_W-1:0] din_r,
  input logic [DATA_W-1:0] dout_r,
  input logic              dvalid_r,
  input logic              collide_r
);

  // R1: outputs are clear in the first cycle after reset
  a_r1_reset_clear_l: assert property (@(posedge clk_l) disable iff (rst_l)
    $fell(rst_l) |-> (!dvalid_l && !collide_l));

  // R2, R4, R5: flow-through valid only after a selected, enabled read
  a_r2_flow_valid_l: assert property (@(posedge clk_l) disable iff (rst_l)
    (dvalid_l && !pipe_l) |-> $past(!ce0_n_l && ce1_l && !wr_l && !oe_n_l));

  // R3: pipelined valid traces back two edges to a selected, enabled read
  a_r3_pipe_valid_r: assert property (@(posedge clk_r) disable iff (rst_r)
    (dvalid_r && pipe_r && $past(pipe_r)) |->
      $past(!ce0_n_r && ce1_r && !wr_r && !oe_n_r, 2));

  // R9: pipelined output holds when the port was deselected
  a_r9_pipe_hold_r: assert property (@(posedge clk_r) disable iff (rst_r)
    (pipe_r && $past(pipe_r) && $past(ce0_n_r || !ce1_r, 2)) |-> $stable(dout_r));

  // R7: a collision flag follows a selected left write two edges earlier
  a_r7_collide_src_l: assert property (@(posedge clk_l) disable iff (rst_l)
    collide_l |-> $past(wr_l && !ce0_n_l && ce1_l, 2));

endmodule

bind dpr_core dpr_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (.*);

// File: tb/dpr_core_tb_top.sv
module dpr_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] din;
    logic [DW-1:0] exp;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 10'd5,   8'hA1, 8'h00},
    '{1'b1, 10'd6,   8'hB2, 8'h00},
    '{1'b0, 10'd5,   8'h00, 8'hA1},
    '{1'b0, 10'd6,   8'h00, 8'hB2},
    '{1'b1, 10'd5,   8'hC3, 8'h00},
    '{1'b1, 10'd1023, 8'h5E, 8'h00},
    '{1'b0, 10'd5,   8'h00, 8'hC3}
  };

  logic clk;
  logic rst_l, ce0_n_l, ce1_l, wr_l, oe_n_l, pipe_l;
  logic rst_r, ce0_n_r, ce1_r, wr_r, oe_n_r, pipe_r;
  logic [AW-1:0] addr_l, addr_r;
  logic [DW-1:0] din_l, din_r, dout_l, dout_r;
  logic dvalid_l, dvalid_r, collide_l, collide_r;

  int n_chk = 0;
  int n_fail = 0;

  dpr_core #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk_l(clk), .rst_l(rst_l), .ce0_n_l(ce0_n_l), .ce1_l(ce1_l), .wr_l(wr_l),
    .oe_n_l(oe_n_l), .pipe_l(pipe_l), .addr_l(addr_l), .din_l(din_l),
    .dout_l(dout_l), .dvalid_l(dvalid_l), .collide_l(collide_l),
    .clk_r(clk), .rst_r(rst_r), .ce0_n_r(ce0_n_r), .ce1_r(ce1_r), .wr_r(wr_r),
    .oe_n_r(oe_n_r), .pipe_r(pipe_r), .addr_r(addr_r), .din_r(din_r),
    .dout_r(dout_r), .dvalid_r(dvalid_r), .collide_r(collide_r)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle_l();
    ce0_n_l = 1'b1; ce1_l = 1'b1; wr_l = 1'b0; oe_n_l = 1'b0;
  endtask

  task automatic idle_r();
    ce0_n_r = 1'b1; ce1_r = 1'b1; wr_r = 1'b0; oe_n_r = 1'b0;
  endtask

  task automatic op_l(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0_n_l = 1'b0; ce1_l = 1'b1; wr_l = w; oe_n_l = 1'b0; addr_l = a; din_l = d;
  endtask

  task automatic op_r(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    ce0_n_r = 1'b0; ce1_r = 1'b1; wr_r = w; oe_n_r = 1'b0; addr_r = a; din_r = d;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: requirement all, actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_l = 1'b1; rst_r = 1'b1; pipe_l = 1'b0; pipe_r = 1'b0;
    addr_l = '0; addr_r = '0; din_l = '0; din_r = '0;
    idle_l(); idle_r();
    @(negedge clk);
    repeat (3) step();
    chk("R1 reset outputs", {12'd0, dvalid_l, dvalid_r, collide_l, collide_r}, 16'd0);
    rst_l = 1'b0; rst_r = 1'b0;
    step();
    chk("R1 after reset", {12'd0, dvalid_l, dvalid_r, collide_l, collide_r}, 16'd0);

    // R2: table walk on the left port, flow-through
    for (int i = 0; i < NV; i++) begin
      op_l(VEC[i].wr, VEC[i].addr, VEC[i].din);
      step();
      idle_l();
      if (VEC[i].wr) chk("R2 write has no valid", {15'd0, dvalid_l}, 16'd0);
      else           chk("R2 flow read", {7'd0, dvalid_l, dout_l}, {8'd1, VEC[i].exp});
    end
    step();

    // R6: cross-port read and simultaneous different-address writes
    op_r(1'b0, 10'd1023, 8'h00); step(); idle_r();
    chk("R6 right reads left data", {7'd0, dvalid_r, dout_r}, {8'd1, 8'h5E});
    op_l(1'b1, 10'd40, 8'h4A); op_r(1'b1, 10'd41, 8'h4B); step();
    idle_l(); idle_r(); step();
    chk("R6 no collision flag", {14'd0, collide_l, collide_r}, 16'd0);
    op_l(1'b0, 10'd41, 8'h00); op_r(1'b0, 10'd40, 8'h00); step();
    idle_l(); idle_r();
    chk("R6 left reads right word", {7'd0, dvalid_l, dout_l}, {8'd1, 8'h4B});
    chk("R6 right reads left word", {7'd0, dvalid_r, dout_r}, {8'd1, 8'h4A});

    // R7: same-address collision, left wins
    op_l(1'b1, 10'd20, 8'h11); op_r(1'b1, 10'd20, 8'h22); step();
    idle_l(); idle_r(); step();
    chk("R7 collision flags set", {14'd0, collide_l, collide_r}, 16'h0003);
    step();
    chk("R7 collision flags one cycle", {14'd0, collide_l, collide_r}, 16'd0);
    op_l(1'b0, 10'd20, 8'h00); op_r(1'b0, 10'd20, 8'h00); step();
    idle_l(); idle_r();
    chk("R7 left data kept (left)", {7'd0, dvalid_l, dout_l}, {8'd1, 8'h11});
    chk("R7 left data kept (right)", {7'd0, dvalid_r, dout_r}, {8'd1, 8'h11});

    // R8: read during write returns old word
    op_l(1'b1, 10'd30, 8'h66); step(); idle_l(); step();
    op_l(1'b1, 10'd30, 8'h77); op_r(1'b0, 10'd30, 8'h00); step();
    idle_l(); idle_r();
    chk("R8 old data on collision read", {7'd0, dvalid_r, dout_r}, {8'd1, 8'h66});
    step();
    op_r(1'b0, 10'd30, 8'h00); step(); idle_r();
    chk("R8 new data afterwards", {7'd0, dvalid_r, dout_r}, {8'd1, 8'h77});

    // R4: deselect variants ignore writes and give no read
    op_l(1'b1, 10'd30, 8'h99); ce1_l = 1'b0; step(); idle_l(); step();
    op_l(1'b1, 10'd30, 8'hAA); ce0_n_l = 1'b1; step(); idle_l(); step();
    op_l(1'b0, 10'd30, 8'h00); ce0_n_l = 1'b1; step(); idle_l();
    chk("R4 deselected read", {7'd0, dvalid_l, dout_l}, 16'd0);
    op_r(1'b0, 10'd30, 8'h00); step(); idle_r();
    chk("R4 deselected writes ignored", {7'd0, dvalid_r, dout_r}, {8'd1, 8'h77});

    // R5: output enable inactive
    op_l(1'b0, 10'd30, 8'h00); oe_n_l = 1'b1; step(); idle_l();
    chk("R5 oe off no valid", {7'd0, dvalid_l, dout_l}, 16'd0);
    op_l(1'b0, 10'd30, 8'h00); step(); idle_l();
    chk("R5 oe on valid", {7'd0, dvalid_l, dout_l}, {8'd1, 8'h77});

    // R3 and R9: pipelined right port
    pipe_r = 1'b1; step(); step();
    op_r(1'b0, 10'd5, 8'h00); step(); idle_r();
    chk("R3 pipelined not yet valid", {15'd0, dvalid_r}, 16'd0);
    step();
    chk("R3 pipelined data", {7'd0, dvalid_r, dout_r}, {8'd1, 8'hC3});
    step(); step();
    chk("R9 pipelined hold deselected", {7'd0, dvalid_r, dout_r}, {8'd0, 8'hC3});
    op_r(1'b0, 10'd30, 8'h00); oe_n_r = 1'b1; step(); idle_r(); step();
    chk("R5 pipelined oe off", {15'd0, dvalid_r}, 16'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule